// File: doc/BRIEF.md
# Bus-Cycle-Aware Reset Controller

This block collects every reason the chip may need a reset: an active-low external reset pin and three internal requests (watchdog timeout, software request, loss of clock). Each request crosses into the system clock domain through a two-stage synchronizer, and the pin must additionally read low on two consecutive synchronized samples before it counts. All activity is clocked. With no clock running, an asserted pin does nothing until clock edges arrive.

Once a valid request is seen, reset is not applied at once. If a bus cycle is under way, the controller waits for the cycle to end, so a write in flight always completes intact. It then asserts three internal reset controls together: a CPU reset, a peripheral reset and an enable that drives the reset pin outward. It records the winning cause in a one-hot register. The controls stay asserted while any request remains and for a fixed number of cycles after the last one clears. While reset is pending or active, the controller blocks every other exception from being taken, which aborts the work in progress.

A power-on reset input initializes the controller itself. It asserts the three controls asynchronously, clears the cause register and then runs the normal hold interval. All ports are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake or back-pressure.

Top module: `safe_reset_ctrl`

## Requirements
- R1: `rst_pin_n` is active low. A low level seen at only one clock edge causes no reset. A low level seen at two consecutive edges k and k+1 asserts the controls after edge k+3, when no bus cycle is active.
- R2: An internal request (`wdog_req`, `soft_req`, `clkloss_req`) first sampled high at edge k, with `bus_busy` low, asserts the controls after edge k+2.
- R3: While `bus_busy` is high and `bus_done` is low, a detected request does not assert the controls. Reset is applied at the first edge that sees `bus_busy` low or `bus_done` high.
- R4: The controls stay asserted until 16 consecutive edges have passed with no synchronized request valid. They are released after the 16th such edge.
- R5: `cpu_rst`, `periph_rst` and `ext_rst_oe` are always equal: they assert and release on the same edge.
- R6: `cause` is one-hot, with bit 0 for the pin, bit 1 for the watchdog, bit 2 for software and bit 3 for loss of clock. It is written only on the edge where a new reset is applied. It picks the highest-priority request among those detected since the reset became pending, in the order pin, loss of clock, watchdog, software.
- R7: `exc_take` equals `exc_req` only when no reset is pending or active and no synchronized request is valid. Otherwise it is 0.
- R8: While `por_n` is low, all three controls are 1 and `cause` is 0. After `por_n` rises, the controls are released after the 16th edge.
- R9: A request that arrives while reset is already asserted leaves `cause` unchanged and restarts the 16-edge hold interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset of the controller, asynchronous, active low |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_req | input | 1 | Watchdog timeout reset request, active high |
| soft_req | input | 1 | Software reset request, active high |
| clkloss_req | input | 1 | Loss-of-clock reset request, active high |
| bus_busy | input | 1 | A bus cycle is in progress |
| bus_done | input | 1 | The current bus cycle ends at this edge |
| exc_req | input | 1 | Some lower-priority exception wants service |
| exc_take | output | 1 | That exception may be taken now |
| cpu_rst | output | 1 | CPU reset control |
| periph_rst | output | 1 | Peripheral reset control |
| ext_rst_oe | output | 1 | Enable for driving the reset pin outward |
| cause | output | 4 | One-hot cause of the last applied reset |

## Verification
Each source is raised alone with the bus idle, and the exact cycle of assertion is checked. This separates the three-edge latency of the qualified pin from the two-edge latency of the internal requests. A pin pulse that lasts one edge, against one that lasts two, shows whether the qualifier actually filters. Requests raised while a bus cycle is held open, then released by `bus_done`, show whether reset waits for the cycle end. Simultaneous or staggered requests, and requests that arrive during the hold, show priority, the freezing of the cause and the restart of the hold count. A long pseudo-random run of all inputs is compared edge by edge against a behavioural model.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NSRC = 4;
  localparam int SRC_PIN  = 0;
  localparam int SRC_WDOG = 1;
  localparam int SRC_SOFT = 2;
  localparam int SRC_CLKL = 3;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_HOLD = 2'd2} seq_t;

  // priority: pin, loss of clock, watchdog, software
  function automatic logic [NSRC-1:0] pick_cause(input logic [NSRC-1:0] v);
    logic [NSRC-1:0] r;
    r = '0;
    if (v[SRC_PIN])       r[SRC_PIN]  = 1'b1;
    else if (v[SRC_CLKL]) r[SRC_CLKL] = 1'b1;
    else if (v[SRC_WDOG]) r[SRC_WDOG] = 1'b1;
    else if (v[SRC_SOFT]) r[SRC_SOFT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rstc_pinqual.sv
module rstc_pinqual #(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic s,
  output logic ok
);
  generate
    if (QUAL <= 1) begin : g_direct
      assign ok = s;
    end else begin : g_hist
      logic [QUAL-2:0] hist;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) hist <= '0;
        else begin
          hist[0] <= s;
          for (int i = 1; i < QUAL-1; i++) hist[i] <= hist[i-1];
        end
      end
      assign ok = s & (&hist);
    end
  endgenerate
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
  import rstc_pkg::*;
#(
  parameter int HOLD_CYC = 16,
  parameter int NOUT     = 3,
  localparam int CW      = $clog2(HOLD_CYC)
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [NSRC-1:0] valid,
  input  logic            bus_busy,
  input  logic            bus_done,
  output logic [NOUT-1:0] rst_o,
  output logic [NSRC-1:0] cause_o,
  output logic            block_o
);
  seq_t st, st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [NSRC-1:0] pend, pend_n, cause_n, seen;
  logic bus_end, any;

  assign bus_end = !bus_busy || bus_done;
  assign any     = |valid;
  assign seen    = pend | valid;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    pend_n  = pend;
    cause_n = cause_o;
    unique case (st)
      ST_IDLE: if (any) begin
        if (bus_end) begin
          st_n = ST_HOLD; cnt_n = '0; cause_n = pick_cause(valid);
        end else begin
          st_n = ST_WAIT; pend_n = valid;
        end
      end
      ST_WAIT: if (bus_end) begin
        st_n = ST_HOLD; cnt_n = '0; cause_n = pick_cause(seen); pend_n = '0;
      end else begin
        pend_n = seen;
      end
      ST_HOLD: if (any) cnt_n = '0;
        else if (cnt == CW'(HOLD_CYC - 1)) st_n = ST_IDLE;
        else cnt_n = cnt + 1'b1;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st <= ST_HOLD; cnt <= '0; pend <= '0; cause_o <= '0;
    end else begin
      st <= st_n; cnt <= cnt_n; pend <= pend_n; cause_o <= cause_n;
    end
  end

  // one flop per reset control, all driven from the next-state decode
  generate
    for (genvar g = 0; g < NOUT; g++) begin : g_out
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rst_o[g] <= 1'b1;
        else        rst_o[g] <= (st_n == ST_HOLD);
      end
    end
  endgenerate

  assign block_o = (st != ST_IDLE) || any;

  // checker: consecutive edges with no valid request
  logic [CW:0] quiet;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) quiet <= '0;
    else if (any) quiet <= '0;
    else if (quiet != (CW+1)'(HOLD_CYC)) quiet <= quiet + 1'b1;
  end

  p_apply_at_bus_end_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_o[0]) |-> $past(!bus_busy || bus_done));

  p_release_after_quiet_r4: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_o[0]) |-> (quiet >= (CW+1)'(HOLD_CYC)));

  p_outputs_together_r5: assert property (@(posedge clk) disable iff (!por_n)
    rst_o == {NOUT{rst_o[0]}});

  p_cause_onehot_r6: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(cause_o));

  p_cause_frozen_r6: assert property (@(posedge clk) disable iff (!por_n)
    !$rose(rst_o[0]) |-> $stable(cause_o));
endmodule

// File: rtl/safe_reset_ctrl.sv
module safe_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIN_QUAL    = 2,
  parameter int HOLD_CYCLES = 16
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_pin_n,
  input  logic            wdog_req,
  input  logic            soft_req,
  input  logic            clkloss_req,
  input  logic            bus_busy,
  input  logic            bus_done,
  input  logic            exc_req,
  output logic            exc_take,
  output logic            cpu_rst,
  output logic            periph_rst,
  output logic            ext_rst_oe,
  output logic [NSRC-1:0] cause
);
  localparam int NOUT = 3;

  logic [NSRC-1:0] raw, synced, valid;
  logic [NOUT-1:0] rst_vec;
  logic            blocked;

  always_comb begin
    raw           = '0;
    raw[SRC_PIN]  = ~rst_pin_n;
    raw[SRC_WDOG] = wdog_req;
    raw[SRC_SOFT] = soft_req;
    raw[SRC_CLKL] = clkloss_req;
  end

  rstc_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .d(raw), .q(synced));

  rstc_pinqual #(.QUAL(PIN_QUAL)) u_qual (
    .clk(clk), .por_n(por_n), .s(synced[SRC_PIN]), .ok(valid[SRC_PIN]));

  assign valid[NSRC-1:1] = synced[NSRC-1:1];

  rstc_seq #(.HOLD_CYC(HOLD_CYCLES), .NOUT(NOUT)) u_seq (
    .clk(clk), .por_n(por_n), .valid(valid), .bus_busy(bus_busy),
    .bus_done(bus_done), .rst_o(rst_vec), .cause_o(cause), .block_o(blocked));

  assign cpu_rst    = rst_vec[0];
  assign periph_rst = rst_vec[1];
  assign ext_rst_oe = rst_vec[2];
  assign exc_take   = exc_req && !blocked;

  p_exc_blocked_r7: assert property (@(posedge clk) disable iff (!por_n)
    exc_take |-> !cpu_rst);
endmodule

// File: tb/sim_safe_reset_ctrl.sv
module sim_safe_reset_ctrl;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin_n = 1'b1, wdog_req = 1'b0, soft_req = 1'b0, clkloss_req = 1'b0;
  logic bus_busy = 1'b0, bus_done = 1'b0, exc_req = 1'b0;
  logic exc_take, cpu_rst, periph_rst, ext_rst_oe;
  logic [3:0] cause;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  safe_reset_ctrl u0 (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wdog_req(wdog_req),
    .soft_req(soft_req), .clkloss_req(clkloss_req), .bus_busy(bus_busy),
    .bus_done(bus_done), .exc_req(exc_req), .exc_take(exc_take),
    .cpu_rst(cpu_rst), .periph_rst(periph_rst), .ext_rst_oe(ext_rst_oe),
    .cause(cause));

  // ---------------- behavioural reference model ----------------
  logic [3:0] hist [$];   // request samples per edge, newest first, bit0 = pin low
  int m_state = 2;        // 0 idle, 1 waiting for bus end, 2 asserted
  int m_cnt = 0;
  logic [3:0] m_cause = 4'b0, m_pend = 4'b0;

  function automatic logic [3:0] m_valid();
    logic [3:0] v;
    v[3:1] = hist[1][3:1];
    v[0]   = hist[1][0] & hist[2][0];
    return v;
  endfunction

  function automatic logic [3:0] m_pick(logic [3:0] v);
    if (v[0]) return 4'b0001;
    if (v[3]) return 4'b1000;
    if (v[1]) return 4'b0010;
    if (v[2]) return 4'b0100;
    return 4'b0000;
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) hist.push_front(4'b0);
  end

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_state = 2; m_cnt = 0; m_cause = 4'b0; m_pend = 4'b0;
      for (int i = 0; i < 3; i++) hist[i] = 4'b0;
    end else begin
      logic [3:0] v;
      logic ends;
      v = m_valid();
      ends = !bus_busy || bus_done;
      if (m_state == 0) begin
        if (v != 0) begin
          if (ends) begin m_state = 2; m_cnt = 0; m_cause = m_pick(v); end
          else begin m_state = 1; m_pend = v; end
        end
      end else if (m_state == 1) begin
        m_pend = m_pend | v;
        if (ends) begin m_state = 2; m_cnt = 0; m_cause = m_pick(m_pend); m_pend = 0; end
      end else begin
        if (v != 0) m_cnt = 0;
        else if (m_cnt == 15) m_state = 0;
        else m_cnt++;
      end
      hist.push_front({clkloss_req, soft_req, wdog_req, ~rst_pin_n});
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic on;
    on = (m_state == 2);
    check("R5 cpu_rst vs model", cpu_rst, on);
    check("R5 periph_rst vs model", periph_rst, on);
    check("R5 ext_rst_oe vs model", ext_rst_oe, on);
    check("R6 cause vs model", cause, m_cause);
    check("R7 exc_take vs model", exc_take,
          exc_req && m_state == 0 && m_valid() == 0);
  end

  // ---------------- stimulus and directed checks ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && cpu_rst; i++) @(negedge clk);
    tick(3);
  endtask

  initial begin
    tick(2);
    check("R8 controls during power-on", cpu_rst, 1);
    check("R8 cause during power-on", cause, 0);
    por_n = 1'b1;
    tick(15);
    check("R4 still held after power-on", cpu_rst, 1);
    tick(1);
    check("R8 released after hold", cpu_rst, 0);
    tick(3);

    // R1: one-edge pin glitch is filtered
    rst_pin_n = 1'b0; tick(1); rst_pin_n = 1'b1;
    tick(6);
    check("R1 glitch ignored", cpu_rst, 0);

    // R1: two-edge pin low applies after edge k+3
    rst_pin_n = 1'b0; tick(2); rst_pin_n = 1'b1;
    tick(1);
    check("R1 not yet applied", cpu_rst, 0);
    tick(1);
    check("R1 pin reset applied", cpu_rst, 1);
    check("R6 pin cause", cause, 4'b0001);
    wait_idle();

    // R2 and R4: watchdog latency and hold count
    wdog_req = 1'b1;
    tick(2);
    check("R2 not yet applied", cpu_rst, 0);
    tick(1);
    check("R2 watchdog reset applied", cpu_rst, 1);
    check("R5 peripheral reset with cpu", periph_rst, 1);
    check("R6 watchdog cause", cause, 4'b0010);
    tick(2);
    wdog_req = 1'b0;
    tick(17);
    check("R4 held through interval", cpu_rst, 1);
    tick(1);
    check("R4 released after 16 quiet edges", cpu_rst, 0);
    check("R5 pin drive released with cpu", ext_rst_oe, 0);
    tick(3);

    // R3 and R7: deferral to bus end, exception blocking
    exc_req = 1'b1;
    tick(1);
    check("R7 exception taken when idle", exc_take, 1);
    bus_busy = 1'b1; soft_req = 1'b1;
    tick(5);
    check("R3 deferred during bus cycle", cpu_rst, 0);
    check("R7 exception blocked while pending", exc_take, 0);
    bus_done = 1'b1;
    tick(1);
    check("R3 applied at bus end", cpu_rst, 1);
    check("R6 software cause", cause, 4'b0100);
    bus_done = 1'b0; bus_busy = 1'b0; soft_req = 1'b0;
    tick(1);
    check("R7 exception blocked during reset", exc_take, 0);
    wait_idle();
    check("R7 exception taken after release", exc_take, 1);
    exc_req = 1'b0;

    // R6: simultaneous internal requests
    wdog_req = 1'b1; soft_req = 1'b1; clkloss_req = 1'b1;
    tick(3);
    check("R6 loss of clock beats watchdog and software", cause, 4'b1000);
    wdog_req = 1'b0; soft_req = 1'b0; clkloss_req = 1'b0;
    wait_idle();

    // R6: staggered requests gathered while waiting, pin wins
    bus_busy = 1'b1; soft_req = 1'b1; rst_pin_n = 1'b0;
    tick(5);
    bus_done = 1'b1;
    tick(1);
    check("R6 pin wins among pending requests", cause, 4'b0001);
    bus_done = 1'b0; bus_busy = 1'b0; soft_req = 1'b0; rst_pin_n = 1'b1;
    wait_idle();

    // R9: request during hold keeps cause, restarts interval
    wdog_req = 1'b1;
    tick(3);
    check("R9 watchdog reset applied", cpu_rst, 1);
    wdog_req = 1'b0;
    tick(5);
    clkloss_req = 1'b1;
    tick(3);
    check("R9 cause unchanged by late request", cause, 4'b0010);
    clkloss_req = 1'b0;
    tick(17);
    check("R9 hold restarted", cpu_rst, 1);
    tick(1);
    check("R9 released after restarted hold", cpu_rst, 0);
    tick(3);

    // mixed pseudo-random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      rst_pin_n   = ($urandom_range(0, 99) < 3) ? 1'b0 : 1'b1;
      wdog_req    = ($urandom_range(0, 99) < 2);
      soft_req    = ($urandom_range(0, 99) < 2);
      clkloss_req = ($urandom_range(0, 99) < 1);
      bus_busy    = ($urandom_range(0, 99) < 60);
      bus_done    = ($urandom_range(0, 99) < 20);
      exc_req     = ($urandom_range(0, 99) < 50);
      tick(1);
    end
    rst_pin_n = 1'b1; wdog_req = 1'b0; soft_req = 1'b0; clkloss_req = 1'b0;
    bus_busy = 1'b0; bus_done = 1'b0; exc_req = 1'b0;
    wait_idle();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule